// File: doc/BRIEF.md
# TDM Audio Codec Slot Port

This block is the codec end of a time-division-multiplexed serial audio link. It runs directly on the serial bit clock. A frame-sync pulse tells it where a frame begins. From then on it counts bit periods in 16-bit slots and claims the first six slots of every frame as its window. Inside the window it shifts in a control word, register write data and DAC samples. At the same time it shifts out a status word, register read-back data and ADC samples. Outside the window its output enable is low, so other devices on the same wires can use the remaining slots.

The ADC sample widths, the DAC sample widths and the DAC mono/stereo packing are set by static configuration pins. Captured words appear on parallel outputs, each with a one-period strobe. ADC samples, read-back data and status flags come in on parallel inputs. These inputs are snapshotted at the start of every frame, so the words sent in one frame are consistent with each other. An end-of-window pulse lets a second device start its own window right after this one. If no new sync arrives, the frame repeats by itself at the selected frame length.

A three-state sequencer controls the frame:
- ST_HUNT: the reset state. No sync has been seen yet.
- ST_WIN: the window is open, frame bits 0 to 95.
- ST_OFF: the window is closed until the frame ends.

Its transitions are:
- Any state goes to ST_WIN on a sync.
- ST_WIN goes to ST_OFF after frame bit 95. This transition raises the end-of-window pulse.
- ST_WIN and ST_OFF go to ST_WIN when the count wraps at the frame length.

Top module: `tdm_codec_port`

## Requirements
- R1: Frame sync timing.
  - `fs` is sampled on the rising edge of `clk`.
  - The bit period that starts at the edge where `fs` is 1 is frame bit 0.
  - `sdo_oe` is high for exactly frame bits 0 to 95 and low for the rest of the frame.
- R2: Slot 0 output carries the status word.
  - Bits are sent MSB first, and `sdo` changes on the rising edge.
  - The status word is {`sts_aux`[12:0], `adc_vld`, `dac2_room`, `dac1_room`}, with `dac1_room` in bit 0.
  - All status inputs are sampled at frame start.
- R3: Register traffic.
  - Slot 1 output carries `rd_data`, sampled at frame start.
  - The word received in slot 0 appears on `ctl_word`, with `ctl_stb` high for frame bit 16.
  - The word received in slot 1 appears on `wr_data`, with `wr_stb` high for frame bit 32.
  - Input bits are sampled on the falling edge, MSB first.
- R4: ADC output packing. An 8-bit ADC sample is the upper byte of its input.
  - Both channels 16-bit: slot 2 = left, slot 3 = right.
  - Both channels 8-bit: slot 2 = {left byte, right byte}, and slot 3 = 0.
  - Left 8-bit only: slot 2 = {left byte, 0x00}.
  - Right 8-bit only: slot 3 = {right byte, 0x00}.
- R5: Output slots 4 and 5 are all zeros.
- R6: DAC stereo 16-bit. DAC1 uses slots 2 and 3, and DAC2 uses slots 4 and 5.
  - The first slot of the pair goes to the left output and the second to the right output.
  - The DAC strobe is high for the bit period after the second slot ends: frame bit 64 for DAC1 and frame bit 96 for DAC2.
- R7: DAC 8-bit and mono packing. Only the first slot of the pair is used, and the strobe comes at frame bit 48 for DAC1 and 80 for DAC2.
  - 8-bit stereo: left = {high byte, 0x00} and right = {low byte, 0x00}.
  - Mono: left and right both get the sample. The sample is the full word, or {high byte, 0x00} when 8-bit.
- R8: A DAC strobe is suppressed when that DAC's room flag, sampled at frame start, is 0. The sample outputs still update.
- R9: Input bits in slots 6 and later are ignored. They cause no strobe and do not change any captured output.
- R10: Frame repetition.
  - Before the first sync, `sdo_oe` stays low.
  - Without further syncs, the window reopens every 256 bit periods when `frame32` is 0, and every 512 when `frame32` is 1.
- R11: `eow` is high for exactly one period, frame bit 96.
- R12: While reset is asserted and right after it, `sdo_oe`, `eow`, every strobe and every captured output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | Frame sync; marks frame bit 0 |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| eow | output | 1 | End-of-window pulse for chaining |
| frame32 | input | 1 | 1 = 32-slot frame, 0 = 16-slot frame |
| adcl_8b | input | 1 | Left ADC channel is 8-bit |
| adcr_8b | input | 1 | Right ADC channel is 8-bit |
| dac1_8b | input | 1 | DAC1 is 8-bit |
| dac1_mono | input | 1 | DAC1 is mono |
| dac2_8b | input | 1 | DAC2 is 8-bit |
| dac2_mono | input | 1 | DAC2 is mono |
| adc_l | input | 16 | Left ADC sample |
| adc_r | input | 16 | Right ADC sample |
| adc_vld | input | 1 | ADC data valid flag |
| dac1_room | input | 1 | DAC1 can accept a sample |
| dac2_room | input | 1 | DAC2 can accept a sample |
| sts_aux | input | 13 | Other status bits |
| rd_data | input | 16 | Register read-back data |
| ctl_word | output | 16 | Received control word |
| ctl_stb | output | 1 | Control word strobe |
| wr_data | output | 16 | Received register data |
| wr_stb | output | 1 | Register data strobe |
| dac1_l | output | 16 | DAC1 left sample |
| dac1_r | output | 16 | DAC1 right sample |
| dac1_stb | output | 1 | DAC1 sample strobe |
| dac2_l | output | 16 | DAC2 left sample |
| dac2_r | output | 16 | DAC2 right sample |
| dac2_stb | output | 1 | DAC2 sample strobe |

## Verification
The case that is hardest to reach from the ports is a frame that starts without a sync. In that case the sequencer must wrap from ST_OFF back to ST_WIN purely on its own count, and the wrap point depends on `frame32`. The stimulus first runs a synced frame that does not chain the next sync. It then clocks a whole frame with `fs` held low, in both 16-slot and 32-slot modes. That second frame is checked for a window of exactly 96 bits and for freshly captured words. Junk bits are also driven in every slot after the window, so that any leak past slot 5 shows up as an extra strobe or a changed captured word.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
    localparam int SLOT_W      = 16;
    localparam int HALF_W      = SLOT_W / 2;
    localparam int WIN_SLOTS   = 6;
    localparam int SHORT_SLOTS = 16;
    localparam int LONG_SLOTS  = 32;
    localparam int BIT_IDX_W   = $clog2(SLOT_W);
    localparam int POS_W       = $clog2(LONG_SLOTS * SLOT_W);
    localparam int SLOT_IDX_W  = POS_W - BIT_IDX_W;
    localparam int WIN_BITS    = WIN_SLOTS * SLOT_W;
    localparam int AUX_W       = SLOT_W - 3;
    localparam int N_DAC       = 2;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_WIN  = 2'd1,
        ST_OFF  = 2'd2
    } tmr_state_t;

    typedef struct packed {
        logic [AUX_W-1:0] aux;
        logic             adc_vld;
        logic             dac2_room;
        logic             dac1_room;
    } status_t;
endpackage

// File: rtl/tdm_frame_timer.sv
`timescale 1ns/1ps
module tdm_frame_timer
    import tdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs,
    input  logic             frame32,
    output logic [POS_W-1:0] pos,
    output logic             in_win,
    output logic             eow,
    output logic             frame_go
);
    localparam logic [POS_W:0] SHORT_BITS = (POS_W+1)'(SHORT_SLOTS * SLOT_W);
    localparam logic [POS_W:0] LONG_BITS  = (POS_W+1)'(LONG_SLOTS * SLOT_W);
    localparam logic [POS_W:0] WIN_END    = (POS_W+1)'(WIN_BITS);

    tmr_state_t       st, st_nx;
    logic [POS_W-1:0] pos_nx;
    logic [POS_W:0]   pos_inc;
    logic [POS_W:0]   frame_bits;

    assign frame_bits = frame32 ? LONG_BITS : SHORT_BITS;
    assign in_win     = (st == ST_WIN);

    always_comb begin
        pos_inc  = {1'b0, pos} + 1'b1;
        st_nx    = st;
        pos_nx   = pos;
        frame_go = 1'b0;
        if (fs) begin
            st_nx    = ST_WIN;
            pos_nx   = '0;
            frame_go = 1'b1;
        end else begin
            unique case (st)
                ST_HUNT: ;
                ST_WIN, ST_OFF: begin
                    if (pos_inc == frame_bits) begin
                        pos_nx   = '0;
                        st_nx    = ST_WIN;
                        frame_go = 1'b1;
                    end else begin
                        pos_nx = pos_inc[POS_W-1:0];
                        if (st == ST_WIN && pos_inc == WIN_END) st_nx = ST_OFF;
                    end
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_HUNT;
            pos <= '0;
        end else begin
            st  <= st_nx;
            pos <= pos_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eow <= 1'b0;
        else        eow <= (st == ST_WIN) && (st_nx == ST_OFF);
    end

    a_r11_eow_single: assert property (@(posedge clk) disable iff (!rst_n)
        eow |=> !eow);
    a_r1_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> ({1'b0, pos} < WIN_END));
endmodule

// File: rtl/tdm_tx.sv
`timescale 1ns/1ps
module tdm_tx
    import tdm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_go,
    input  logic                  in_win,
    input  logic [SLOT_IDX_W-1:0] slot,
    input  logic [BIT_IDX_W-1:0]  bidx,
    input  logic                  adcl_8b,
    input  logic                  adcr_8b,
    input  logic [SLOT_W-1:0]     adc_l,
    input  logic [SLOT_W-1:0]     adc_r,
    input  status_t               sts_in,
    input  logic [SLOT_W-1:0]     rd_data,
    output logic                  room1_q,
    output logic                  room2_q,
    output logic                  sdo,
    output logic                  sdo_oe
);
    localparam logic [BIT_IDX_W-1:0] BIT_TOP = BIT_IDX_W'(SLOT_W - 1);

    status_t           sts_q;
    logic [SLOT_W-1:0] rdd_q, a2_q, a3_q;
    logic [SLOT_W-1:0] a2, a3, word;

    always_comb begin
        a2 = adc_l;
        a3 = adc_r;
        if (adcl_8b && adcr_8b) begin
            a2 = {adc_l[SLOT_W-1:HALF_W], adc_r[SLOT_W-1:HALF_W]};
            a3 = '0;
        end else if (adcl_8b) begin
            a2 = {adc_l[SLOT_W-1:HALF_W], {HALF_W{1'b0}}};
        end else if (adcr_8b) begin
            a3 = {adc_r[SLOT_W-1:HALF_W], {HALF_W{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            rdd_q <= '0;
            a2_q  <= '0;
            a3_q  <= '0;
        end else if (frame_go) begin
            sts_q <= sts_in;
            rdd_q <= rd_data;
            a2_q  <= a2;
            a3_q  <= a3;
        end
    end

    always_comb begin
        unique case (slot)
            SLOT_IDX_W'(0): word = sts_q;
            SLOT_IDX_W'(1): word = rdd_q;
            SLOT_IDX_W'(2): word = a2_q;
            SLOT_IDX_W'(3): word = a3_q;
            default:        word = '0;
        endcase
    end

    assign sdo     = in_win & word[BIT_TOP - bidx];
    assign sdo_oe  = in_win;
    assign room1_q = sts_q.dac1_room;
    assign room2_q = sts_q.dac2_room;
endmodule

// File: rtl/tdm_dac_lane.sv
`timescale 1ns/1ps
module tdm_dac_lane
    import tdm_pkg::*;
#(
    parameter int BASE_SLOT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  done,
    input  logic [SLOT_IDX_W-1:0] dslot,
    input  logic [SLOT_W-1:0]     word,
    input  logic                  w8,
    input  logic                  mono,
    input  logic                  room,
    output logic [SLOT_W-1:0]     smp_l,
    output logic [SLOT_W-1:0]     smp_r,
    output logic                  stb
);
    localparam logic [SLOT_IDX_W-1:0] FIRST  = SLOT_IDX_W'(BASE_SLOT);
    localparam logic [SLOT_IDX_W-1:0] SECOND = SLOT_IDX_W'(BASE_SLOT + 1);

    logic [SLOT_W-1:0] hi_byte, lo_byte, mono_smp;

    assign hi_byte  = {word[SLOT_W-1:HALF_W], {HALF_W{1'b0}}};
    assign lo_byte  = {word[HALF_W-1:0], {HALF_W{1'b0}}};
    assign mono_smp = w8 ? hi_byte : word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_l <= '0;
            smp_r <= '0;
            stb   <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (done && dslot == FIRST) begin
                if (mono) begin
                    smp_l <= mono_smp;
                    smp_r <= mono_smp;
                    stb   <= room;
                end else if (w8) begin
                    smp_l <= hi_byte;
                    smp_r <= lo_byte;
                    stb   <= room;
                end else begin
                    smp_l <= word;
                end
            end else if (done && dslot == SECOND && !mono && !w8) begin
                smp_r <= word;
                stb   <= room;
            end
        end
    end

    a_r8_stb_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> $past(room));
endmodule

// File: rtl/tdm_rx.sv
`timescale 1ns/1ps
module tdm_rx
    import tdm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sdi,
    input  logic                          in_win,
    input  logic [SLOT_IDX_W-1:0]         slot,
    input  logic [BIT_IDX_W-1:0]          bidx,
    input  logic [N_DAC-1:0]              dac_8b,
    input  logic [N_DAC-1:0]              dac_mono,
    input  logic [N_DAC-1:0]              dac_room,
    output logic [SLOT_W-1:0]             ctl_word,
    output logic                          ctl_stb,
    output logic [SLOT_W-1:0]             wr_data,
    output logic                          wr_stb,
    output logic [N_DAC-1:0][SLOT_W-1:0]  dac_l,
    output logic [N_DAC-1:0][SLOT_W-1:0]  dac_r,
    output logic [N_DAC-1:0]              dac_stb
);
    localparam logic [BIT_IDX_W-1:0] BIT_TOP = BIT_IDX_W'(SLOT_W - 1);

    logic [SLOT_W-1:0]     sh;
    logic                  done;
    logic [SLOT_IDX_W-1:0] dslot;

    // falling-edge capture
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            done  <= 1'b0;
            dslot <= '0;
        end else begin
            done <= 1'b0;
            if (in_win) begin
                sh <= {sh[SLOT_W-2:0], sdi};
                if (bidx == BIT_TOP) begin
                    done  <= 1'b1;
                    dslot <= slot;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_word <= '0;
            ctl_stb  <= 1'b0;
            wr_data  <= '0;
            wr_stb   <= 1'b0;
        end else begin
            ctl_stb <= done && (dslot == SLOT_IDX_W'(0));
            wr_stb  <= done && (dslot == SLOT_IDX_W'(1));
            if (done && dslot == SLOT_IDX_W'(0)) ctl_word <= sh;
            if (done && dslot == SLOT_IDX_W'(1)) wr_data  <= sh;
        end
    end

    for (genvar g = 0; g < N_DAC; g++) begin : g_lane
        tdm_dac_lane #(.BASE_SLOT(2 + 2 * g)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .done  (done),
            .dslot (dslot),
            .word  (sh),
            .w8    (dac_8b[g]),
            .mono  (dac_mono[g]),
            .room  (dac_room[g]),
            .smp_l (dac_l[g]),
            .smp_r (dac_r[g]),
            .stb   (dac_stb[g])
        );
    end

    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_stb, wr_stb, dac_stb}));
    a_r3_ctl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stb |=> !ctl_stb);
endmodule

// File: rtl/tdm_codec_port.sv
`timescale 1ns/1ps
module tdm_codec_port
    import tdm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fs,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_oe,
    output logic        eow,
    input  logic        frame32,
    input  logic        adcl_8b,
    input  logic        adcr_8b,
    input  logic        dac1_8b,
    input  logic        dac1_mono,
    input  logic        dac2_8b,
    input  logic        dac2_mono,
    input  logic [15:0] adc_l,
    input  logic [15:0] adc_r,
    input  logic        adc_vld,
    input  logic        dac1_room,
    input  logic        dac2_room,
    input  logic [12:0] sts_aux,
    input  logic [15:0] rd_data,
    output logic [15:0] ctl_word,
    output logic        ctl_stb,
    output logic [15:0] wr_data,
    output logic        wr_stb,
    output logic [15:0] dac1_l,
    output logic [15:0] dac1_r,
    output logic        dac1_stb,
    output logic [15:0] dac2_l,
    output logic [15:0] dac2_r,
    output logic        dac2_stb
);
    logic [POS_W-1:0]               pos;
    logic                           in_win, frame_go;
    logic                           room1_q, room2_q;
    status_t                        sts_in;
    logic [N_DAC-1:0][SLOT_W-1:0]   dl, dr;
    logic [N_DAC-1:0]               dstb;

    assign sts_in = '{aux: sts_aux, adc_vld: adc_vld, dac2_room: dac2_room, dac1_room: dac1_room};

    tdm_frame_timer u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs       (fs),
        .frame32  (frame32),
        .pos      (pos),
        .in_win   (in_win),
        .eow      (eow),
        .frame_go (frame_go)
    );

    tdm_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_go (frame_go),
        .in_win   (in_win),
        .slot     (pos[POS_W-1:BIT_IDX_W]),
        .bidx     (pos[BIT_IDX_W-1:0]),
        .adcl_8b  (adcl_8b),
        .adcr_8b  (adcr_8b),
        .adc_l    (adc_l),
        .adc_r    (adc_r),
        .sts_in   (sts_in),
        .rd_data  (rd_data),
        .room1_q  (room1_q),
        .room2_q  (room2_q),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    tdm_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdi      (sdi),
        .in_win   (in_win),
        .slot     (pos[POS_W-1:BIT_IDX_W]),
        .bidx     (pos[BIT_IDX_W-1:0]),
        .dac_8b   ({dac2_8b, dac1_8b}),
        .dac_mono ({dac2_mono, dac1_mono}),
        .dac_room ({room2_q, room1_q}),
        .ctl_word (ctl_word),
        .ctl_stb  (ctl_stb),
        .wr_data  (wr_data),
        .wr_stb   (wr_stb),
        .dac_l    (dl),
        .dac_r    (dr),
        .dac_stb  (dstb)
    );

    assign dac1_l   = dl[0];
    assign dac1_r   = dr[0];
    assign dac1_stb = dstb[0];
    assign dac2_l   = dl[1];
    assign dac2_r   = dr[1];
    assign dac2_stb = dstb[1];

    a_r1_oe_fall_eow: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> eow);
endmodule

// File: tb/tb_tdm_codec_port.sv
`timescale 1ns/1ps
module tb_tdm_codec_port;
    logic        clk = 1'b0, rst_n = 1'b0, fs = 1'b0, sdi = 1'b0;
    logic        frame32 = 1'b0, adcl_8b = 1'b0, adcr_8b = 1'b0;
    logic        dac1_8b = 1'b0, dac1_mono = 1'b0, dac2_8b = 1'b0, dac2_mono = 1'b0;
    logic [15:0] adc_l = '0, adc_r = '0, rd_data = '0;
    logic        adc_vld = 1'b0, dac1_room = 1'b0, dac2_room = 1'b0;
    logic [12:0] sts_aux = '0;
    logic        sdo, sdo_oe, eow, ctl_stb, wr_stb, dac1_stb, dac2_stb;
    logic [15:0] ctl_word, wr_data, dac1_l, dac1_r, dac2_l, dac2_r;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 1'b0;
    logic [511:0] r_oe, r_sdo, r_eow, r_ctl, r_wr, r_d1, r_d2;

    always #2 clk = ~clk;

    tdm_codec_port dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [511:0] v, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic int first_one(input logic [511:0] v, input int n);
        for (int i = 0; i < n; i++) if (v[i]) return i;
        return 999;
    endfunction

    function automatic logic [15:0] out_word(input int s);
        logic [15:0] w;
        for (int b = 0; b < 16; b++) w[15-b] = r_sdo[16*s+b];
        return w;
    endfunction

    function automatic logic [31:0] dac_exp(input bit w8, input bit mono,
                                            input logic [15:0] a, input logic [15:0] b);
        logic [15:0] s;
        s = w8 ? {a[15:8], 8'h00} : a;
        if (mono) return {s, s};
        if (w8)   return {a[15:8], 8'h00, a[7:0], 8'h00};
        return {a, b};
    endfunction

    function automatic logic [31:0] adc_exp();
        if (adcl_8b && adcr_8b) return {adc_l[15:8], adc_r[15:8], 16'h0000};
        if (adcl_8b)            return {adc_l[15:8], 8'h00, adc_r};
        if (adcr_8b)            return {adc_l, adc_r[15:8], 8'h00};
        return {adc_l, adc_r};
    endfunction

    task automatic sync_pulse();
        @(posedge clk); #1 fs = 1'b1;
    endtask

    task automatic run_frame(input int nbits, input logic [5:0][15:0] win,
                             input logic [15:0] junk, input bit chain);
        r_oe = '0; r_sdo = '0; r_eow = '0; r_ctl = '0; r_wr = '0; r_d1 = '0; r_d2 = '0;
        for (int i = 0; i < nbits; i++) begin
            @(posedge clk); #1;
            fs  = chain && (i == nbits - 1);
            sdi = (i < 96) ? win[i/16][15 - (i%16)] : junk[15 - (i%16)];
            #2;
            r_oe[i] = sdo_oe; r_sdo[i] = sdo; r_eow[i] = eow;
            r_ctl[i] = ctl_stb; r_wr[i] = wr_stb; r_d1[i] = dac1_stb; r_d2[i] = dac2_stb;
        end
    endtask

    task automatic verify(input string nm, input int nbits, input logic [5:0][15:0] win);
        logic [31:0] ae, d1e, d2e;
        int b1, b2;
        ae  = adc_exp();
        d1e = dac_exp(dac1_8b, dac1_mono, win[2], win[3]);
        d2e = dac_exp(dac2_8b, dac2_mono, win[4], win[5]);
        b1  = (!dac1_mono && !dac1_8b) ? 64 : 48;
        b2  = (!dac2_mono && !dac2_8b) ? 96 : 80;
        $display("-- %s", nm);
        chk("R1 oe count", ones(r_oe, nbits), 96);
        chk("R1 oe span", {31'd0, &r_oe[95:0]}, 1);
        chk("R11 eow count", ones(r_eow, nbits), 1);
        chk("R11 eow pos", first_one(r_eow, nbits), 96);
        chk("R2 status word", out_word(0), {sts_aux, adc_vld, dac2_room, dac1_room});
        chk("R3 readback word", out_word(1), rd_data);
        chk("R4 adc slots", {out_word(2), out_word(3)}, ae);
        chk("R5 zero slots", {out_word(4), out_word(5)}, 0);
        chk("R3 ctl_word", ctl_word, win[0]);
        chk("R3 ctl_stb pos", first_one(r_ctl, nbits), 16);
        chk("R3 wr_stb pos", first_one(r_wr, nbits), 32);
        chk("R9 wr_data unchanged by junk", wr_data, win[1]);
        chk("R9 ctl strobes only once", ones(r_ctl, nbits) + ones(r_wr, nbits), 2);
        chk("R6 R7 dac1 samples", {dac1_l, dac1_r}, d1e);
        chk("R6 R7 dac2 samples", {dac2_l, dac2_r}, d2e);
        if (dac1_room) begin
            chk("R6 R7 dac1 strobe count", ones(r_d1, nbits), 1);
            chk("R6 R7 dac1 strobe pos", first_one(r_d1, nbits), b1);
        end else
            chk("R8 dac1 strobe suppressed", ones(r_d1, nbits), 0);
        if (dac2_room) begin
            chk("R6 R7 dac2 strobe count", ones(r_d2, nbits), 1);
            chk("R6 R7 dac2 strobe pos", first_one(r_d2, nbits), b2);
        end else
            chk("R8 dac2 strobe suppressed", ones(r_d2, nbits), 0);
    endtask

    task automatic t_reset();
        int seen = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R12 oe in reset", sdo_oe, 0);
        chk("R12 eow in reset", eow, 0);
        chk("R12 strobes in reset", {ctl_stb, wr_stb, dac1_stb, dac2_stb}, 0);
        chk("R12 outputs in reset", {ctl_word, wr_data}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R12 dac outputs after reset", {dac1_l, dac2_r}, 0);
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #3;
            seen += int'(sdo_oe);
        end
        chk("R10 no window before sync", seen, 0);
    endtask

    task automatic t_stereo16();
        frame32 = 0; adcl_8b = 0; adcr_8b = 0;
        dac1_8b = 0; dac1_mono = 0; dac2_8b = 0; dac2_mono = 0;
        adc_l = 16'h1234; adc_r = 16'h5678; adc_vld = 1; dac1_room = 1; dac2_room = 1;
        sts_aux = 13'h1A5A; rd_data = 16'hC0DE;
        sync_pulse();
        run_frame(256, {16'hD1D2, 16'hC1C2, 16'hB1B2, 16'hA1A2, 16'h4D2E, 16'h8001}, 16'hFFFF, 1'b0);
        verify("R6 stereo 16-bit", 256, {16'hD1D2, 16'hC1C2, 16'hB1B2, 16'hA1A2, 16'h4D2E, 16'h8001});
    endtask

    task automatic t_eight_mono();
        adcl_8b = 1; adcr_8b = 1; dac1_8b = 1; dac1_mono = 0; dac2_8b = 0; dac2_mono = 1;
        adc_l = 16'h9A11; adc_r = 16'h3C22; adc_vld = 0; dac1_room = 1; dac2_room = 1;
        sts_aux = 13'h0F0F; rd_data = 16'h0BAD;
        sync_pulse();
        run_frame(256, {16'h6666, 16'h7E81, 16'h5555, 16'hA5C3, 16'h1357, 16'h2468}, 16'h5A5A, 1'b0);
        verify("R7 8-bit stereo and mono", 256, {16'h6666, 16'h7E81, 16'h5555, 16'hA5C3, 16'h1357, 16'h2468});
    endtask

    task automatic t_mixed_noroom();
        adcl_8b = 1; adcr_8b = 0; dac1_8b = 1; dac1_mono = 1; dac2_8b = 1; dac2_mono = 0;
        adc_l = 16'hE0E1; adc_r = 16'h7777; adc_vld = 1; dac1_room = 0; dac2_room = 1;
        sts_aux = 13'h0001; rd_data = 16'hFACE;
        sync_pulse();
        run_frame(256, {16'h0000, 16'h9ABC, 16'h4242, 16'hB4C5, 16'hFEDC, 16'h0F1E}, 16'hA5A5, 1'b0);
        verify("R8 mixed widths, no room", 256, {16'h0000, 16'h9ABC, 16'h4242, 16'hB4C5, 16'hFEDC, 16'h0F1E});
    endtask

    task automatic t_freerun();
        adcl_8b = 0; adcr_8b = 1; dac1_8b = 0; dac1_mono = 0; dac2_8b = 0; dac2_mono = 0;
        adc_l = 16'h0102; adc_r = 16'hCD03; dac1_room = 1; dac2_room = 1;
        frame32 = 0;
        sync_pulse();
        run_frame(256, {16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666}, 16'h0000, 1'b0);
        verify("R10 short frame synced", 256, {16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666});
        run_frame(256, {16'h8888, 16'h9999, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD}, 16'hFFFF, 1'b0);
        verify("R10 short frame without sync", 256, {16'h8888, 16'h9999, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD});
        frame32 = 1;
        sync_pulse();
        run_frame(512, {16'h0A0B, 16'h1C1D, 16'h2E2F, 16'h3031, 16'h4243, 16'h5455}, 16'hFFFF, 1'b0);
        verify("R10 long frame synced", 512, {16'h0A0B, 16'h1C1D, 16'h2E2F, 16'h3031, 16'h4243, 16'h5455});
        run_frame(512, {16'h7071, 16'h8283, 16'h9495, 16'hA6A7, 16'hB8B9, 16'hCACB}, 16'h3C3C, 1'b0);
        verify("R10 long frame without sync", 512, {16'h7071, 16'h8283, 16'h9495, 16'hA6A7, 16'hB8B9, 16'hCACB});
    endtask

    initial begin
        #(4 * 20000);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stereo16();
        t_eight_mono();
        t_mixed_noroom();
        t_freerun();
        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule